// File: doc/BRIEF.md
# PS/2 Device-Side Host Byte Receiver

This block is the receiving half of the device end of a PS/2 link. The host wants to send a command, so it holds the data line low while the clock line floats high. The block watches for that condition. It qualifies the request over several ticks of a slow bit-rate enable, then drives the clock itself, one bit cell at a time, and shifts in the frame the host places on the data line. The bus lines are open-collector, so the block only ever asserts a pull-low enable on the clock line. Both line inputs arrive already synchronized.

Every state change happens on a cycle where `tick` is high. A bit cell is two ticks long. On the sampling tick the released clock must read high, the data line is captured, and the clock is pulled low. On the following tick the clock is released again. When the frame is complete, the data byte goes into a one-entry buffer with a valid/ready handshake. Error and abort flags sit beside the byte. A force input keeps the block listening even while the host leaves the data line high.

`busy` is high for as long as a request check or a reception is in progress. A neighbouring transmit block uses it as its lock-out.

Top module: `ps2_host_rx`

## Requirements
- R1: While idle, a tick that sees the clock line high and the data line low starts request checking; `busy` is high whenever checking or receiving is in progress and low otherwise.
- R2: During checking, each tick acts on the line state: if data is high, checking ends; if clock is low and data is low, the qualifying count holds; if clock is high and data is low, the count advances.
- R3: The third qualifying tick of a check starts reception in the same cycle and clears `rx_err` and `rx_abort`.
- R4: With `force_rx` high, an idle tick starts checking whatever the lines show, and data high does not end checking; once `force_rx` is low again, data high ends it.
- R5: Reception has two phases. On the first tick after acceptance, and on every second tick after that, the block samples the data line and asserts `ps2_clk_pull`. On the tick in between, it releases the clock. A full frame takes 11 samples.
- R6: If the clock line reads low on a sampling tick, the transfer stops: `rx_abort` is set, the clock is released and the block returns to idle.
- R7: The frame is sampled in this order: start bit, data bit 0 (LSB) through data bit 7, parity bit, stop bit. On completion, `rx_data` holds the 8 data bits.
- R8: `rx_err` is set at completion if the data bits plus the parity bit hold an even number of ones (odd parity expected), if the stop sample is 0, or if the start sample is 1.
- R9: On the sampling tick after the stop bit, data low means the host wants more clocks. The block then sets `rx_err`, clocks one more bit cell without changing the captured frame, and repeats the check. It completes on the first such tick that sees data high.
- R10: Completion sets `rx_valid` with the new byte. `rx_valid` clears after a cycle with `rx_valid` and `rx_ready` both high. If completion falls in that same cycle, `rx_valid` stays set with the new byte.
- R11: `rx_err` and `rx_abort` keep their value until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-bit-cell enable, one cycle wide |
| ps2_clk_i | input | 1 | Synchronized clock line level |
| ps2_data_i | input | 1 | Synchronized data line level |
| force_rx | input | 1 | Keep listening for a request even when data is high |
| ps2_clk_pull | output | 1 | 1 = pull the clock line low |
| busy | output | 1 | Checking or receiving; locks out the transmitter |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Consumer takes the byte |
| rx_err | output | 1 | Parity, framing or over-clock error in the last reception |
| rx_abort | output | 1 | Host stopped the last reception by holding the clock low |

## Verification
Two functions can fall in the same cycle: the consumer taking the old byte and the engine finishing a new one. The bench provokes this by leaving one byte unread and then pulsing `rx_ready` on the exact cycle the reference model predicts the next frame will complete. It then judges that `rx_valid` stays high and `rx_data` shows the new byte. A second pairing puts the over-clock decision and the release of the data line on the same sampling tick. A host that keeps data low for two extra cells exercises this pairing, and the bench expects both extra clock pulses and the error flag.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_HIGH = 2'd1,
    ENG_LOW  = 2'd2
  } eng_state_t;

  // Running odd-parity accumulator: only payload and parity samples count.
  function automatic logic parity_step(input logic acc, input logic smp, input logic counts);
    return counts ? (acc ^ smp) : acc;
  endfunction

  // Frame is good when the accumulator came back to zero (odd ones),
  // the start sample was low and the stop sample was high.
  function automatic logic frame_accept(input logic acc, input logic start_smp,
                                        input logic stop_smp);
    return !acc && !start_smp && stop_smp;
  endfunction

endpackage

// File: rtl/ps2r_req_qual.sv
module ps2r_req_qual #(
  parameter int REQ_TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic line_clk,
  input  logic line_data,
  input  logic force_rx,
  output logic checking,
  output logic accept
);

  localparam int CW = $clog2(REQ_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;
  logic          qualify;

  assign cnt_next = cnt + 1'b1;
  assign qualify  = tick && checking && !line_data && line_clk;
  assign accept   = qualify && (cnt_next == CW'(REQ_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      checking <= 1'b0;
      cnt      <= '0;
    end else if (tick) begin
      if (!checking) begin
        if (enable && (force_rx || (line_clk && !line_data))) begin
          checking <= 1'b1;
          cnt      <= '0;
        end
      end else if (line_data) begin
        if (!force_rx) checking <= 1'b0;
      end else if (line_clk) begin
        if (accept) begin
          checking <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt_next;
        end
      end
    end
  end

  // R2: a data-high tick never moves the qualifying count
  a_r2_hold_on_data_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && checking && line_data) |=> (cnt == $past(cnt)));

  // R2: clock low with data low keeps checking and the count
  a_r2_wait_on_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && checking && !line_clk && !line_data) |=> (checking && cnt == $past(cnt)));

endmodule

// File: rtl/ps2r_bit_engine.sv
module ps2r_bit_engine
  import ps2r_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              line_clk,
  input  logic              line_data,
  output logic              active,
  output logic              clk_pull,
  output logic              done,
  output logic              frame_bad,
  output logic              abort_evt,
  output logic              overclk_evt,
  output logic [DATA_W-1:0] data
);

  localparam int FRAME_W = DATA_W + 3;
  localparam int CW      = $clog2(FRAME_W + 2);

  eng_state_t         state;
  logic [CW-1:0]      n;
  logic [FRAME_W-1:0] sr;
  logic               acc;

  logic sample_tick;
  logic at_last;
  logic take_bit;
  logic par_bit;

  assign sample_tick = tick && (state == ENG_HIGH);
  assign at_last     = (n == CW'(FRAME_W));
  assign take_bit    = sample_tick && !at_last && line_clk;
  assign par_bit     = (n >= CW'(1)) && (n <= CW'(DATA_W + 1));

  assign done        = sample_tick && at_last && line_data;
  assign overclk_evt = sample_tick && at_last && !line_data;
  assign abort_evt   = sample_tick && !at_last && !line_clk;
  assign frame_bad   = !frame_accept(acc, sr[0], sr[FRAME_W-1]);
  assign data        = sr[DATA_W:1];
  assign active      = (state != ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      n        <= '0;
      sr       <= '0;
      acc      <= 1'b0;
      clk_pull <= 1'b0;
    end else if (start) begin
      state    <= ENG_HIGH;
      n        <= '0;
      acc      <= 1'b1;
      clk_pull <= 1'b0;
    end else if (tick) begin
      case (state)
        ENG_HIGH: begin
          if (at_last) begin
            if (line_data) begin
              state <= ENG_IDLE;
            end else begin
              clk_pull <= 1'b1;
              state    <= ENG_LOW;
            end
          end else if (!line_clk) begin
            clk_pull <= 1'b0;
            state    <= ENG_IDLE;
          end else begin
            sr       <= {line_data, sr[FRAME_W-1:1]};
            acc      <= parity_step(acc, line_data, par_bit);
            n        <= n + 1'b1;
            clk_pull <= 1'b1;
            state    <= ENG_LOW;
          end
        end
        ENG_LOW: begin
          clk_pull <= 1'b0;
          state    <= ENG_HIGH;
        end
        default: ;
      endcase
    end
  end

  // R6: an abort leaves the engine idle with the clock released
  a_r6_abort_releases: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!active && !clk_pull));

  // R9: an over-clock request is answered with another low clock phase
  a_r9_extra_cell: assert property (@(posedge clk) disable iff (!rst_n)
    overclk_evt |=> (clk_pull && $stable(sr)));

  // R5: the clock enable only moves on ticks
  a_r5_pull_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(clk_pull));

  // R5: a sampled bit is always followed by a pulled clock
  a_r5_sample_then_pull: assert property (@(posedge clk) disable iff (!rst_n)
    take_bit |=> clk_pull);

endmodule

// File: rtl/ps2r_rx_buf.sv
module ps2r_rx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              done,
  input  logic              frame_bad,
  input  logic              abort_evt,
  input  logic              overclk_evt,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_err,
  output logic              rx_abort
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (done) begin
      rx_data  <= data_in;
      rx_valid <= 1'b1;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_err   <= 1'b0;
      rx_abort <= 1'b0;
    end else if (clear) begin
      rx_err   <= 1'b0;
      rx_abort <= 1'b0;
    end else begin
      if (overclk_evt || (done && frame_bad)) rx_err <= 1'b1;
      if (abort_evt) rx_abort <= 1'b1;
    end
  end

  // R10: an unread byte stays put until the consumer takes it
  a_r10_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));

  // R3: acceptance of a request wipes the status flags
  a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!rx_err && !rx_abort));

  // R11: flags never drop without an acceptance
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !clear) |=> rx_err);

endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx #(
  parameter int DATA_W    = 8,
  parameter int REQ_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  input  logic              force_rx,
  output logic              ps2_clk_pull,
  output logic              busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_err,
  output logic              rx_abort
);

  logic              checking;
  logic              accept;
  logic              active;
  logic              done;
  logic              frame_bad;
  logic              abort_evt;
  logic              overclk_evt;
  logic [DATA_W-1:0] eng_data;

  ps2r_req_qual #(.REQ_TICKS(REQ_TICKS)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .enable    (!active),
    .line_clk  (ps2_clk_i),
    .line_data (ps2_data_i),
    .force_rx  (force_rx),
    .checking  (checking),
    .accept    (accept)
  );

  ps2r_bit_engine #(.DATA_W(DATA_W)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start       (accept),
    .line_clk    (ps2_clk_i),
    .line_data   (ps2_data_i),
    .active      (active),
    .clk_pull    (ps2_clk_pull),
    .done        (done),
    .frame_bad   (frame_bad),
    .abort_evt   (abort_evt),
    .overclk_evt (overclk_evt),
    .data        (eng_data)
  );

  ps2r_rx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .done        (done),
    .frame_bad   (frame_bad),
    .abort_evt   (abort_evt),
    .overclk_evt (overclk_evt),
    .data_in     (eng_data),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_err      (rx_err),
    .rx_abort    (rx_abort)
  );

  assign busy = checking || active;

  // R1: request checking and reception never overlap
  a_r1_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(checking && active));

  // R5: the clock is only driven while the block is busy
  a_r5_pull_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_pull |-> busy);

endmodule

// File: tb/test_ps2_host_rx.sv
module test_ps2_host_rx;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       force_rx = 1'b0;
  logic       rx_ready = 1'b0;
  logic       host_hold = 1'b0;
  logic       dline = 1'b1;
  logic       ps2_clk_pull;
  logic       busy;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_err;
  logic       rx_abort;
  logic       ps2_clk_i;

  assign ps2_clk_i = ~(ps2_clk_pull | host_hold);

  ps2_host_rx i_ps2_host_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .ps2_clk_i    (ps2_clk_i),
    .ps2_data_i   (dline),
    .force_rx     (force_rx),
    .ps2_clk_pull (ps2_clk_pull),
    .busy         (busy),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_ready     (rx_ready),
    .rx_err       (rx_err),
    .rx_abort     (rx_abort)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int tdiv = 0;
  bit finished = 0;

  // host side
  bit host_active = 0;
  bit hq[$];
  logic prev_bus = 1'b1;
  bit ready_req = 0;
  bit ready_auto = 0;

  // reference model: 0 idle, 1 checking, 2 sampling phase, 3 low phase
  int         m_st = 0;
  int         m_rq = 0;
  int         m_n = 0;
  int         m_bits[11];
  logic       m_pull = 1'b0;
  logic       m_valid = 1'b0;
  logic       m_err = 1'b0;
  logic       m_abort = 1'b0;
  logic [7:0] m_data = 8'h00;
  int         m_done_cnt = 0;
  int         m_abort_cnt = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    logic lc;
    logic dl;
    int ones;
    if (!rst_n) begin
      m_st = 0; m_rq = 0; m_n = 0; m_pull = 0;
      m_valid = 0; m_err = 0; m_abort = 0; m_data = 0;
    end else begin
      lc = !(m_pull || host_hold);
      dl = dline;
      if (m_valid && rx_ready) m_valid = 0;
      if (tick) begin
        case (m_st)
          0: if (force_rx || (lc && !dl)) begin m_st = 1; m_rq = 0; end
          1: begin
            if (dl) begin
              if (!force_rx) m_st = 0;
            end else if (lc) begin
              m_rq++;
              if (m_rq == 3) begin
                m_st = 2; m_rq = 0; m_n = 0; m_err = 0; m_abort = 0;
              end
            end
          end
          2: begin
            if (m_n == 11) begin
              if (dl) begin
                ones = 0;
                for (int i = 0; i < 8; i++) begin
                  m_data[i] = m_bits[i+1][0];
                  ones += m_bits[i+1];
                end
                ones += m_bits[9];
                if ((ones % 2) == 0 || m_bits[10] == 0 || m_bits[0] == 1) m_err = 1;
                m_valid = 1;
                m_st = 0;
                m_done_cnt++;
              end else begin
                m_err = 1; m_pull = 1; m_st = 3;
              end
            end else if (!lc) begin
              m_abort = 1; m_pull = 0; m_st = 0; m_abort_cnt++;
            end else begin
              m_bits[m_n] = int'(dl);
              m_n++;
              m_pull = 1;
              m_st = 3;
            end
          end
          default: begin m_pull = 0; m_st = 2; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      check(ps2_clk_pull === m_pull, "R5", "ps2_clk_pull", int'(ps2_clk_pull), int'(m_pull));
      check(busy === (m_st != 0), "R1", "busy", int'(busy), int'(m_st != 0));
      check(rx_valid === m_valid, "R10", "rx_valid", int'(rx_valid), int'(m_valid));
      check(rx_data === m_data, "R7", "rx_data", int'(rx_data), int'(m_data));
      check(rx_err === m_err, "R8", "rx_err", int'(rx_err), int'(m_err));
      check(rx_abort === m_abort, "R6", "rx_abort", int'(rx_abort), int'(m_abort));
    end
    if (host_active && prev_bus && !ps2_clk_i) begin
      if (hq.size() > 0) dline = hq.pop_front();
      else dline = 1'b1;
    end
    prev_bus = ps2_clk_i;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0);
    rx_ready = ready_req || (ready_auto && tick && m_st == 2 && m_n == 11 && dline);
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                      input int extra_low);
    int d0;
    bit p;
    p = ~^b;
    if (bad_par) p = ~p;
    hq.delete();
    for (int i = 0; i < 8; i++) hq.push_back(b[i]);
    hq.push_back(p);
    hq.push_back(!bad_stop);
    for (int i = 0; i < extra_low; i++) hq.push_back(1'b0);
    d0 = m_done_cnt;
    host_active = 1;
    dline = 1'b0;
    while (m_done_cnt == d0) step(1);
    step(2);
    host_active = 0;
    dline = 1'b1;
  endtask

  task automatic read_byte();
    ready_req = 1;
    step(2);
    ready_req = 0;
    step(1);
    check(rx_valid == 1'b0, "R10", "valid after read", int'(rx_valid), 0);
  endtask

  initial begin
    int a0;
    int pulls;
    rst_n = 1'b0;
    step(5);
    rst_n = 1'b1;
    step(1);
    // reset state
    check(ps2_clk_pull == 0, "R5", "reset clk_pull", int'(ps2_clk_pull), 0);
    check(busy == 0, "R1", "reset busy", int'(busy), 0);
    check(rx_valid == 0 && rx_err == 0 && rx_abort == 0, "R10", "reset flags",
          int'({rx_valid, rx_err, rx_abort}), 0);

    // R7 plain frame
    send(8'hA5, 0, 0, 0);
    check(rx_valid == 1, "R10", "valid after frame", int'(rx_valid), 1);
    check(rx_data == 8'hA5, "R7", "data A5", int'(rx_data), 'hA5);
    check(rx_err == 0, "R8", "no error on good frame", int'(rx_err), 0);
    read_byte();

    // R8 bad parity
    send(8'h3C, 1, 0, 0);
    check(rx_err == 1, "R8", "parity error", int'(rx_err), 1);
    check(rx_data == 8'h3C, "R7", "data 3C", int'(rx_data), 'h3C);
    read_byte();

    // R11 flag survives idle time
    step(40);
    check(rx_err == 1, "R11", "error sticky", int'(rx_err), 1);

    // R8 bad stop, R3 clears earlier error first
    send(8'h81, 0, 1, 0);
    check(rx_err == 1, "R8", "stop error", int'(rx_err), 1);
    read_byte();

    // R3 good frame clears error
    send(8'h11, 0, 0, 0);
    check(rx_err == 0, "R3", "error cleared on accept", int'(rx_err), 0);
    read_byte();

    // R9 over-clocking: two extra low cells, count clock pulses
    pulls = 0;
    fork
      send(8'h5A, 0, 0, 2);
      begin
        while (host_active == 0) step(1);
        while (host_active) begin
          @(posedge ps2_clk_pull or negedge host_active);
          if (ps2_clk_pull) pulls++;
        end
      end
    join
    check(rx_err == 1, "R9", "overclock error", int'(rx_err), 1);
    check(rx_data == 8'h5A, "R9", "data kept through extra cells", int'(rx_data), 'h5A);
    check(pulls == 13, "R5", "clock pulses with two extra cells", pulls, 13);
    read_byte();

    // R6 host holds clock low mid-frame
    hq.delete();
    for (int i = 0; i < 10; i++) hq.push_back(i[0]);
    a0 = m_abort_cnt;
    host_active = 1;
    dline = 1'b0;
    while (!(m_st == 3 && m_n == 4)) step(1);
    host_hold = 1'b1;
    while (m_abort_cnt == a0) step(1);
    step(1);
    check(rx_abort == 1, "R6", "abort flag", int'(rx_abort), 1);
    check(busy == 0, "R6", "idle after abort", int'(busy), 0);
    check(rx_valid == 0, "R6", "no byte after abort", int'(rx_valid), 0);
    host_active = 0;
    hq.delete();
    dline = 1'b1;
    step(4);
    host_hold = 1'b0;
    step(3 * TICK_DIV);
    check(rx_abort == 1, "R11", "abort sticky", int'(rx_abort), 1);

    // R2 data high during check ends it
    dline = 1'b0;
    while (m_st != 1) step(1);
    dline = 1'b1;
    step(3 * TICK_DIV);
    check(busy == 0, "R2", "data high ends check", int'(busy), 0);

    // R2 clock low with data low waits
    dline = 1'b0;
    while (m_st != 1) step(1);
    host_hold = 1'b1;
    step(6 * TICK_DIV);
    check(busy == 1, "R2", "still checking while clock low", int'(busy), 1);
    check(ps2_clk_pull == 0, "R2", "no reception while clock low", int'(ps2_clk_pull), 0);
    host_hold = 1'b0;
    step(1);
    send(8'h42, 0, 0, 0);
    check(rx_data == 8'h42, "R3", "accept after wait", int'(rx_data), 'h42);
    read_byte();

    // R4 forced listening
    force_rx = 1'b1;
    dline = 1'b1;
    step(3 * TICK_DIV);
    check(busy == 1, "R4", "force enters check", int'(busy), 1);
    step(8 * TICK_DIV);
    check(busy == 1, "R4", "force survives data high", int'(busy), 1);
    send(8'h99, 0, 0, 0);
    check(rx_data == 8'h99, "R4", "byte under force", int'(rx_data), 'h99);
    read_byte();
    force_rx = 1'b0;
    step(3 * TICK_DIV);
    check(busy == 0, "R4", "check ends without force", int'(busy), 0);

    // R10 read and completion in the same cycle
    send(8'h0F, 0, 0, 0);
    check(rx_valid == 1, "R10", "first byte pending", int'(rx_valid), 1);
    ready_auto = 1;
    send(8'hF0, 0, 0, 0);
    ready_auto = 0;
    check(rx_valid == 1, "R10", "valid kept on collision", int'(rx_valid), 1);
    check(rx_data == 8'hF0, "R10", "new byte on collision", int'(rx_data), 'hF0);
    read_byte();

    step(10);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule